// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside a read path that corrects single-bit errors and detects double-bit errors. On every read it receives two strobes, one for a corrected single-bit error and one for an uncorrectable multi-bit error. With those strobes come the 32-bit access address and the 8-bit syndrome.

The first error seen while the block is armed is frozen into one 32-bit host-visible status word. That word holds the upper address bits, the syndrome and a sticky flag that names the error type. Software re-arms capture by writing 1 to both flag bits in the same write.

The same word carries three host-writable controls:
- A scrub disable. When scrubbing is enabled, every corrected read produces a one-cycle write-back request.
- An enable for an NMI request on single-bit errors.
- An enable for a bus-error output on multi-bit errors.

Top module: `ecc_err_capture`

## Requirements
- R1: After synchronous reset, `rd_data` is 0 and `scrub_req`, `nmi_req` and `bus_err` are 0. Scrubbing is therefore enabled and both the NMI and bus-error enables are off.
- R2: A multi-bit error strobe while armed takes effect in the cycle after the strobe, as follows:
  - `rd_data[30:12]` becomes `addr_i[31:13]`.
  - `rd_data[11:4]` becomes `syn_i`.
  - `rd_data[1]` (MBE flag) becomes 1.
- R3: A single-bit error strobe while armed has the same effect on `rd_data[30:12]` and `rd_data[11:4]`, and sets `rd_data[0]` (SBE flag) instead of the MBE flag.
- R4: If both strobes arrive in the same armed cycle, the multi-bit error is recorded and only the MBE flag is set. The two flags are never 1 together.
- R5: While either flag is 1, capture is not armed. Later error strobes leave `rd_data[30:4]` and both flags unchanged.
- R6: A host write with `wr_data[1:0]` = 2'b11 clears both flags and re-arms capture. A write with only one of these two bits set, or with neither set, leaves the flags unchanged.
- R7: Every host write loads `rd_data[31]` (scrub disable), `rd_data[3]` (bus-error enable) and `rd_data[2]` (NMI enable) from the matching `wr_data` bits. Written values of bits 30:4 have no effect.
- R8: With `rd_data[31]` = 0, a single-bit strobe without a multi-bit strobe gives a one-cycle `scrub_req` in the next cycle, with `scrub_addr` equal to that `addr_i`. This happens whether or not capture is armed. With `rd_data[31]` = 1 no scrub request is made.
- R9: `nmi_req` is 1 in the cycle after a single-bit strobe exactly when `rd_data[2]` was 1, whether or not capture is armed.
- R10: `bus_err` is 1 in the cycle after a multi-bit strobe exactly when `rd_data[3]` was 1, whether or not capture is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_i | input | 1 | Corrected single-bit error on this read |
| mbe_i | input | 1 | Uncorrectable multi-bit error on this read |
| addr_i | input | 32 | Address of this read |
| syn_i | input | 8 | ECC syndrome of this read |
| wr_en | input | 1 | Host write strobe for the status word |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Status word as read by the host |
| scrub_req | output | 1 | Write-back request for a corrected read |
| scrub_addr | output | 32 | Address to scrub, valid with `scrub_req` |
| nmi_req | output | 1 | NMI request on a single-bit error |
| bus_err | output | 1 | Bus-error signal on a multi-bit error |

## Verification
The bench drives random strobe streams in which strobes are sometimes isolated, sometimes simultaneous and sometimes arrive while a flag is already set. This separates correct first-error capture and MBE priority from designs that overwrite on later errors. Host writes use random data as well as the directed patterns 2'b01, 2'b10 and 2'b11 in the flag bits, so a half clear is told apart from a full clear. Control bits are toggled between runs of strobes, so the scrub, NMI and bus-error pulses are checked both with the capture armed and with it frozen.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int ADDR_W  = 32;
  localparam int SYN_W   = 8;
  localparam int GRAN    = 13;
  localparam int AHI_W   = ADDR_W - GRAN;
  localparam int REG_W   = 32;
  // status word bit positions
  localparam int B_SBE   = 0;
  localparam int B_MBE   = 1;
  localparam int B_NMIEN = 2;
  localparam int B_BEREN = 3;
  localparam int B_SYN   = 4;
  localparam int B_ADDR  = B_SYN + SYN_W;
  localparam int B_SCDIS = REG_W - 1;

  typedef struct packed {
    logic scrub_dis;
    logic berr_en;
    logic nmi_en;
  } ctrl_t;
endpackage

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
  import ecc_cap_pkg::*;
#(
  parameter int REGW = REG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [REGW-1:0] wr_data,
  output ctrl_t           ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_en) begin
      ctrl.scrub_dis <= wr_data[B_SCDIS];
      ctrl.berr_en   <= wr_data[B_BEREN];
      ctrl.nmi_en    <= wr_data[B_NMIEN];
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl)); // R7
endmodule

// File: rtl/ecc_capture_core.sv
module ecc_capture_core
  import ecc_cap_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int SW   = SYN_W,
  parameter int GR   = GRAN,
  localparam int HW  = AW - GR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sbe_i,
  input  logic          mbe_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] syn_i,
  input  logic          wr_en,
  input  logic [1:0]    wr_flags,
  output logic          sbe_q,
  output logic          mbe_q,
  output logic [HW-1:0] ahi_q,
  output logic [SW-1:0] syn_q
);
  logic armed, hit, full_clr;

  assign armed    = !sbe_q && !mbe_q;
  assign hit      = armed && (sbe_i || mbe_i);
  assign full_clr = wr_en && (wr_flags == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
      ahi_q <= '0;
      syn_q <= '0;
    end else if (hit) begin
      ahi_q <= addr_i[AW-1:GR];
      syn_q <= syn_i;
      mbe_q <= mbe_i;
      sbe_q <= !mbe_i;
    end else if (full_clr) begin
      sbe_q <= 1'b0;
      mbe_q <= 1'b0;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    !(sbe_q && mbe_q)); // R4
  AST_MBE_WINS: assert property (@(posedge clk) disable iff (rst)
    (armed && mbe_i) |=> (mbe_q && !sbe_q)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !armed |=> ($stable(ahi_q) && $stable(syn_q))); // R5
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!armed && full_clr) |=> (!sbe_q && !mbe_q)); // R6
  AST_NO_HALF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!armed && !full_clr) |=> (!armed && $stable(sbe_q))); // R6
endmodule

// File: rtl/ecc_event_out.sv
module ecc_event_out
  import ecc_cap_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sbe_i,
  input  logic          mbe_i,
  input  logic [AW-1:0] addr_i,
  input  ctrl_t         ctrl,
  output logic          scrub_req,
  output logic [AW-1:0] scrub_addr,
  output logic          nmi_req,
  output logic          bus_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scrub_req  <= 1'b0;
      scrub_addr <= '0;
      nmi_req    <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      scrub_req  <= sbe_i && !mbe_i && !ctrl.scrub_dis;
      scrub_addr <= addr_i;
      nmi_req    <= sbe_i && ctrl.nmi_en;
      bus_err    <= mbe_i && ctrl.berr_en;
    end
  end

  AST_SCRUB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    scrub_req |-> $past(sbe_i && !ctrl.scrub_dis)); // R8
  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> $past(sbe_i && ctrl.nmi_en)); // R9
  AST_BERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(mbe_i && ctrl.berr_en)); // R10
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SYN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [SW-1:0]     syn_i,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              scrub_req,
  output logic [AW-1:0]     scrub_addr,
  output logic              nmi_req,
  output logic              bus_err
);
  localparam int HW = AW - GRAN;

  ctrl_t          ctrl;
  logic           sbe_q, mbe_q;
  logic [HW-1:0]  ahi_q;
  logic [SW-1:0]  syn_q;

  ecc_ctrl_regs #(.REGW(REG_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
  );

  ecc_capture_core #(.AW(AW), .SW(SW), .GR(GRAN)) u_core (
    .clk(clk), .rst(rst), .sbe_i(sbe_i), .mbe_i(mbe_i),
    .addr_i(addr_i), .syn_i(syn_i), .wr_en(wr_en),
    .wr_flags(wr_data[B_MBE:B_SBE]),
    .sbe_q(sbe_q), .mbe_q(mbe_q), .ahi_q(ahi_q), .syn_q(syn_q)
  );

  ecc_event_out #(.AW(AW)) u_evt (
    .clk(clk), .rst(rst), .sbe_i(sbe_i), .mbe_i(mbe_i), .addr_i(addr_i),
    .ctrl(ctrl), .scrub_req(scrub_req), .scrub_addr(scrub_addr),
    .nmi_req(nmi_req), .bus_err(bus_err)
  );

  assign rd_data = {ctrl.scrub_dis, ahi_q, syn_q, ctrl.berr_en, ctrl.nmi_en,
                    mbe_q, sbe_q};

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && !scrub_req && !nmi_req && !bus_err)); // R1
  AST_CAPTURE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (!sbe_q && !mbe_q && (sbe_i || mbe_i)) |=>
      (rd_data[B_SCDIS-1:B_ADDR] == $past(addr_i[AW-1:GRAN]))); // R2
endmodule

// File: tb/tb_ecc_err_capture.sv
module tb_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst;
  logic        sbe_i, mbe_i, wr_en;
  logic [31:0] addr_i, wr_data;
  logic [7:0]  syn_i;
  logic [31:0] rd_data, scrub_addr;
  logic        scrub_req, nmi_req, bus_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model of the status word and outputs
  logic        m_sd, m_ben, m_nen, m_sbe, m_mbe;
  logic [18:0] m_ahi;
  logic [7:0]  m_syn;
  logic        m_scrub, m_nmi, m_berr;
  logic [31:0] m_saddr;

  always #5 clk = ~clk;

  ecc_err_capture dut (
    .clk(clk), .rst(rst), .sbe_i(sbe_i), .mbe_i(mbe_i), .addr_i(addr_i),
    .syn_i(syn_i), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .scrub_req(scrub_req), .scrub_addr(scrub_addr), .nmi_req(nmi_req),
    .bus_err(bus_err)
  );

  function automatic logic [31:0] exp_word();
    return {m_sd, m_ahi, m_syn, m_ben, m_nen, m_mbe, m_sbe};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sd = 0; m_ben = 0; m_nen = 0; m_sbe = 0; m_mbe = 0;
    m_ahi = '0; m_syn = '0; m_scrub = 0; m_nmi = 0; m_berr = 0; m_saddr = '0;
  endtask

  task automatic model_step(input logic s, input logic m, input logic [31:0] a,
                            input logic [7:0] y, input logic we, input logic [31:0] wd);
    logic armed;
    armed   = !m_sbe && !m_mbe;
    m_scrub = s && !m && !m_sd;
    m_saddr = a;
    m_nmi   = s && m_nen;
    m_berr  = m && m_ben;
    if (armed && (s || m)) begin
      m_ahi = a[31:13]; m_syn = y; m_mbe = m; m_sbe = !m;
    end else if (we && wd[1:0] == 2'b11) begin
      m_sbe = 0; m_mbe = 0;
    end
    if (we) begin
      m_sd = wd[31]; m_ben = wd[3]; m_nen = wd[2];
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 R3 R5 R6 R7 status"}, rd_data, exp_word());
    chk({tag, " R8 scrub_req"}, {31'b0, scrub_req}, {31'b0, m_scrub});
    if (m_scrub) chk({tag, " R8 scrub_addr"}, scrub_addr, m_saddr);
    chk({tag, " R9 nmi_req"}, {31'b0, nmi_req}, {31'b0, m_nmi});
    chk({tag, " R10 bus_err"}, {31'b0, bus_err}, {31'b0, m_berr});
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input string tag, input logic s, input logic m,
                      input logic [31:0] a, input logic [7:0] y,
                      input logic we, input logic [31:0] wd);
    sbe_i = s; mbe_i = m; addr_i = a; syn_i = y; wr_en = we; wr_data = wd;
    @(posedge clk);
    model_step(s, m, a, y, we, wd);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 32'h0, 8'h0, 0, 32'h0);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1; sbe_i = 0; mbe_i = 0; addr_i = 0; syn_i = 0; wr_en = 0; wr_data = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 reset rd_data", rd_data, 32'h0);
    chk("R1 reset outs", {29'b0, scrub_req, nmi_req, bus_err}, 32'h0);

    // R2 MBE capture, enables on
    step("R7 ctrl write", 0, 0, 0, 0, 1, 32'h0000_000C);
    step("R2 mbe", 0, 1, 32'hDEAD_BEEF, 8'hA5, 0, 0);
    // R5 later errors ignored while frozen; R10 still pulses, R9/R8 too
    step("R5 sbe frozen", 1, 0, 32'h1234_5678, 8'h3C, 0, 0);
    step("R5 mbe frozen", 0, 1, 32'hFFFF_FFFF, 8'hFF, 0, 0);
    // R6 half clears do nothing
    step("R6 half clr 01", 0, 0, 0, 0, 1, 32'h0000_000D);
    step("R6 half clr 10", 0, 0, 0, 0, 1, 32'h0000_000E);
    step("R6 zero clr", 0, 0, 0, 0, 1, 32'h7FFF_FFFC);
    // R6 full clear, R7 bits 30:4 ignored
    step("R6 full clr", 0, 0, 0, 0, 1, 32'h7FFF_FFF3);
    // R3 SBE capture with scrub disabled (R8 no scrub)
    step("R7 scrub dis", 0, 0, 0, 0, 1, 32'h8000_0000);
    step("R3 sbe", 1, 0, 32'h0000_2000, 8'h11, 0, 0);
    step("R6 clr", 0, 0, 0, 0, 1, 32'h0000_0003);
    // R4 simultaneous strobes
    step("R4 both", 1, 1, 32'hCAFE_0000, 8'h77, 0, 0);
    step("R6 clr+err same cycle", 1, 0, 32'h0BAD_0000, 8'h01, 1, 32'h0000_0003);
    step("R3 rearmed sbe", 1, 0, 32'h0001_E000, 8'h22, 0, 0);
    idle("idle");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic s, m, we;
      logic [31:0] wd;
      r  = $urandom;
      s  = (r[3:0] < 3);
      m  = (r[7:4] < 2);
      we = (r[11:8] < 3);
      wd = $urandom;
      if (r[12]) wd[1:0] = 2'b11;
      step("rand", s, m, $urandom, 8'($urandom), we, wd);
    end

    // R1 reset again from a busy state
    rst = 1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;
    chk("R1 reset again", rd_data, 32'h0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule